// File: doc/BRIEF.md
# Processor Status Word Register

This block keeps the eight-bit status word of a small accumulator-style processor core. The word carries three bank-select bits used by the data-memory address logic, two read-only health bits that record watchdog and low-power history, and three arithmetic flags: zero, digit carry (carry out of bit 3) and carry (carry out of bit 7). In subtraction the two carry flags mean "no borrow", because the ALU adds the two's complement of the subtrahend. On rotates the carry flag takes the bit that was shifted out. The ALU works out these flag values. This block only stores them.

Every cycle the register can take three kinds of input at once. It can take an instruction write of the whole byte. It can take per-flag update enables with the ALU's flag results. It can take event strobes for power-up, watchdog clear, sleep entry and watchdog time-out. The merge rules protect the flags and the health bits. When an instruction that changes any flag also writes the status word, the written data does not reach the flag bits. The health bits never take written data. Only the event strobes change them.

The output is the registered status byte. It changes one clock after the inputs are applied.

Top module: `psw_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the status word becomes 8'h18: bank bits 0, both health bits 1, all flags 0.
- R2: Bit positions of `status_q`: [7] indirect bank select, [6] and [5] direct bank select high and low, [4] no-time-out bit, [3] not-powered-down bit, [2] zero flag, [1] digit carry flag, [0] carry flag.
- R3: A write (`wr_en`=1) loads `wr_data[7:5]` into the bank bits on the next edge, whether or not any flag update is enabled.
- R4: Bits [4] and [3] ignore `wr_data` completely. With no event strobe they keep their value through any write or flag update.
- R5: When `flag_upd[i]` is 1, flag i takes `alu_flags[i]` on the next edge, even if a write is also present. Index 2 is zero, 1 is digit carry and 0 is carry.
- R6: When a write coincides with at least one flag update, a flag whose update is not enabled keeps its old value. A clear of the status word by an instruction that changes only the zero flag therefore gives bank 000, health bits unchanged, zero flag 1, digit carry and carry unchanged.
- R7: A write with no flag update enabled loads `wr_data[2:0]` into the three flags. With no write, only flags whose update is enabled change, and the bank bits hold.
- R8: A power-up or watchdog-clear event sets both health bits to 1.
- R9: A sleep event sets bit [4] to 1 and clears bit [3].
- R10: A watchdog time-out clears bit [4] and leaves bit [3] unchanged.
- R11: When several events arrive in the same cycle, the priority is power-up, then time-out, then watchdog clear, then sleep. Only the winning event takes effect.
- R12: Event strobes change only bits [4:3]. The bank bits and the flags follow R3, R5 and R7 as if no event were present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Instruction writes the status word this cycle |
| wr_data | input | 8 | Byte written by the instruction |
| flag_upd | input | 3 | Per-flag update enables {zero, digit carry, carry} |
| alu_flags | input | 3 | ALU flag results {zero, digit carry, carry} |
| ev_powerup | input | 1 | Power-up event strobe |
| ev_wdt_clear | input | 1 | Watchdog-clear event strobe |
| ev_sleep | input | 1 | Sleep-entry event strobe |
| ev_wdt_timeout | input | 1 | Watchdog time-out strobe |
| status_q | output | 8 | Current status word |

## Verification
The hardest case to reach is a write that lands in the same cycle as a partial flag update. The protected flags must already hold values that differ from the written data, or a wrong merge would not show. The stimulus first writes a pattern with digit carry and carry set. It then applies a clear-style write of zero together with an update of the zero flag alone, so any leak of data into the unselected flags becomes visible. The health bits get the same treatment. A sleep and a time-out first bring them to values that differ from the written bits, and later writes must leave those values intact.

// File: rtl/psw_pkg.sv
// Package: shared widths, bit positions and the resolved health-event type
// for the processor status word. Assumes an 8-bit word with bank bits on top.
package psw_pkg;
    localparam int PSW_W   = 8;
    localparam int BANK_W  = 3;
    localparam int FLAG_W  = 3;
    localparam int POS_TO  = 4;
    localparam int POS_PD  = 3;
    localparam int BANK_LO = PSW_W - BANK_W;

    // Reset value of the whole word: only the two health bits are set.
    localparam logic [PSW_W-1:0] PSW_RST = (PSW_W'(1) << POS_TO) | (PSW_W'(1) << POS_PD);

    // Health-bit event after priority resolution.
    typedef enum logic [2:0] {
        HEV_NONE,
        HEV_SLEEP,
        HEV_WDCLR,
        HEV_TMO,
        HEV_PWRUP
    } health_ev_e;

    // Packed view of the status word, MSB first.
    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              no_tmo;
        logic              no_pdn;
        logic [FLAG_W-1:0] flags;
    } psw_t;
endpackage

// File: rtl/psw_bank_reg.sv
// Bank-select field of the status word. Any instruction write loads it;
// nothing else changes it. Assumes the caller slices the proper data bits.
module psw_bank_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_bits,
    output logic [W-1:0] bank_q
);
    // Bank storage: cleared on reset, loaded on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else if (wr_en)
            bank_q <= wr_bits;
    end
endmodule

// File: rtl/psw_flag_reg.sv
// Arithmetic flag field. Each flag takes the ALU value when its update is
// enabled. A write reaches the flags only when no update is enabled in that
// cycle, so an instruction that sets flags cannot overwrite them with its data.
module psw_flag_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_bits,
    input  logic [N-1:0] upd,
    input  logic [N-1:0] alu,
    output logic [N-1:0] flags_q
);
    logic wr_guard;

    // Any flag update in this cycle protects all flags from written data.
    always_comb wr_guard = |upd;

    for (genvar i = 0; i < N; i++) begin : g_flag
        // One flag bit: ALU value, then unguarded write, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_q[i] <= 1'b0;
            else if (upd[i])
                flags_q[i] <= alu[i];
            else if (wr_en && !wr_guard)
                flags_q[i] <= wr_bits[i];
        end
    end
endmodule

// File: rtl/psw_health_reg.sv
// Time-out and power-down bits. Instruction writes never reach them; only
// event strobes do. Simultaneous events resolve as power-up, time-out,
// watchdog clear, then sleep.
module psw_health_reg
    import psw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_pwrup,
    input  logic ev_wdclr,
    input  logic ev_sleep,
    input  logic ev_tmo,
    output logic no_tmo_q,
    output logic no_pdn_q
);
    health_ev_e ev_win;

    // Pick the single event that takes effect this cycle.
    always_comb begin
        if (ev_pwrup)      ev_win = HEV_PWRUP;
        else if (ev_tmo)   ev_win = HEV_TMO;
        else if (ev_wdclr) ev_win = HEV_WDCLR;
        else if (ev_sleep) ev_win = HEV_SLEEP;
        else               ev_win = HEV_NONE;
    end

    // Apply the winning event to the two health bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            no_tmo_q <= 1'b1;
            no_pdn_q <= 1'b1;
        end else begin
            case (ev_win)
                HEV_PWRUP, HEV_WDCLR: begin
                    no_tmo_q <= 1'b1;
                    no_pdn_q <= 1'b1;
                end
                HEV_TMO:   no_tmo_q <= 1'b0;
                HEV_SLEEP: begin
                    no_tmo_q <= 1'b1;
                    no_pdn_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/psw_reg.sv
// Processor status word register. Merges instruction writes, ALU flag
// updates and health events into one registered byte. Assumes the ALU
// presents flag values and enables in the cycle the instruction retires.
module psw_reg
    import psw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PSW_W-1:0]  wr_data,
    input  logic [FLAG_W-1:0] flag_upd,
    input  logic [FLAG_W-1:0] alu_flags,
    input  logic              ev_powerup,
    input  logic              ev_wdt_clear,
    input  logic              ev_sleep,
    input  logic              ev_wdt_timeout,
    output logic [PSW_W-1:0]  status_q
);
    psw_t word;

    psw_bank_reg #(.W(BANK_W)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bits (wr_data[PSW_W-1:BANK_LO]),
        .bank_q  (word.bank)
    );

    psw_health_reg i_health (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_pwrup (ev_powerup),
        .ev_wdclr (ev_wdt_clear),
        .ev_sleep (ev_sleep),
        .ev_tmo   (ev_wdt_timeout),
        .no_tmo_q (word.no_tmo),
        .no_pdn_q (word.no_pdn)
    );

    psw_flag_reg #(.N(FLAG_W)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bits (wr_data[FLAG_W-1:0]),
        .upd     (flag_upd),
        .alu     (alu_flags),
        .flags_q (word.flags)
    );

    // Present the packed word on the output.
    always_comb status_q = word;
endmodule

// File: rtl/psw_reg_chk.sv
// Checker for psw_reg: relates the inputs to the registered word one cycle later.
module psw_reg_chk
    import psw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [PSW_W-1:0]  wr_data,
    input logic [FLAG_W-1:0] flag_upd,
    input logic [FLAG_W-1:0] alu_flags,
    input logic              ev_powerup,
    input logic              ev_wdt_clear,
    input logic              ev_sleep,
    input logic              ev_wdt_timeout,
    input logic [PSW_W-1:0]  status_q
);
    logic any_ev;
    always_comb any_ev = ev_powerup | ev_wdt_clear | ev_sleep | ev_wdt_timeout;

    assert_bank_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> status_q[PSW_W-1:BANK_LO] == $past(wr_data[PSW_W-1:BANK_LO]));

    assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(status_q[PSW_W-1:BANK_LO]));

    assert_health_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ev |=> $stable(status_q[POS_TO:POS_PD]));

    assert_pwrup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_powerup |=> status_q[POS_TO] && status_q[POS_PD]);

    assert_wdclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wdt_clear && !ev_wdt_timeout) |=> status_q[POS_TO] && status_q[POS_PD]);

    assert_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sleep && !ev_powerup && !ev_wdt_timeout && !ev_wdt_clear)
        |=> status_q[POS_TO] && !status_q[POS_PD]);

    assert_tmo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wdt_timeout && !ev_powerup)
        |=> !status_q[POS_TO] && status_q[POS_PD] == $past(status_q[POS_PD]));

    for (genvar i = 0; i < FLAG_W; i++) begin : g_chk
        assert_alu_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
            flag_upd[i] |=> status_q[i] == $past(alu_flags[i]));

        assert_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (flag_upd != '0) && !flag_upd[i]) |=> $stable(status_q[i]));

        assert_plain_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && flag_upd == '0) |=> status_q[i] == $past(wr_data[i]));
    end
endmodule

bind psw_reg psw_reg_chk i_psw_reg_chk (.*);

// File: tb/test_psw_reg.sv
// Directed bench for psw_reg: one task per scenario, each checks its results.
module test_psw_reg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [2:0] flag_upd;
    logic [2:0] alu_flags;
    logic       ev_powerup, ev_wdt_clear, ev_sleep, ev_wdt_timeout;
    logic [7:0] status_q;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psw_reg i_psw_reg (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .flag_upd       (flag_upd),
        .alu_flags      (alu_flags),
        .ev_powerup     (ev_powerup),
        .ev_wdt_clear   (ev_wdt_clear),
        .ev_sleep       (ev_sleep),
        .ev_wdt_timeout (ev_wdt_timeout),
        .status_q       (status_q)
    );

    task automatic check(input string req, input logic [7:0] exp);
        n_checks++;
        if (status_q !== exp) begin
            n_fail++;
            $display("FAIL %s: status_q=%h expected=%h", req, status_q, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_data = 0; flag_upd = 0; alu_flags = 0;
        ev_powerup = 0; ev_wdt_clear = 0; ev_sleep = 0; ev_wdt_timeout = 0;
    endtask

    // Apply one cycle of stimulus at a falling edge; result visible at the next one.
    // ev = {powerup, wdt_clear, sleep, wdt_timeout}
    task automatic step(input logic wr, input logic [7:0] d, input logic [2:0] up,
                        input logic [2:0] al, input logic [3:0] ev);
        wr_en = wr; wr_data = d; flag_upd = up; alu_flags = al;
        {ev_powerup, ev_wdt_clear, ev_sleep, ev_wdt_timeout} = ev;
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset();
        step(1, 8'hFF, 3'b111, 3'b111, 4'b0000);
        do_reset();
        check("R1 R2 reset word", 8'h18);
    endtask

    task automatic t_plain_write();
        do_reset();
        step(1, 8'hA5, 3'b000, 3'b000, 4'b0000);
        check("R3 R7 plain write", 8'hBD);
        step(1, 8'h00, 3'b000, 3'b000, 4'b0000);
        check("R4 write zeros keeps health bits", 8'h18);
        step(0, 8'h00, 3'b000, 3'b000, 4'b0010);
        step(1, 8'hFF, 3'b000, 3'b000, 4'b0000);
        check("R4 write ones keeps PD clear", 8'hF7);
    endtask

    task automatic t_alu_update();
        do_reset();
        step(1, 8'h03, 3'b000, 3'b000, 4'b0000);
        check("R7 set dc and c", 8'h1B);
        step(0, 8'h00, 3'b101, 3'b100, 4'b0000);
        check("R7 partial update, bank holds", 8'h1E);
        step(1, 8'hFF, 3'b111, 3'b000, 4'b0000);
        check("R5 R3 alu wins over write", 8'hF8);
    endtask

    task automatic t_clear_instr();
        do_reset();
        step(1, 8'hE3, 3'b000, 3'b000, 4'b0000);
        check("R3 preload", 8'hFB);
        step(1, 8'h00, 3'b100, 3'b100, 4'b0000);
        check("R6 clear instruction 000u u1uu", 8'h1F);
        step(1, 8'h04, 3'b001, 3'b000, 4'b0000);
        check("R6 zero flag guarded", 8'h1E);
    endtask

    task automatic t_events();
        do_reset();
        step(0, 8'h00, 3'b000, 3'b000, 4'b0010);
        check("R9 sleep", 8'h10);
        step(0, 8'h00, 3'b000, 3'b000, 4'b0001);
        check("R10 timeout keeps PD", 8'h00);
        step(0, 8'h00, 3'b000, 3'b000, 4'b0100);
        check("R8 watchdog clear", 8'h18);
        step(0, 8'h00, 3'b000, 3'b000, 4'b0001);
        check("R10 timeout", 8'h08);
        step(0, 8'h00, 3'b000, 3'b000, 4'b1000);
        check("R8 power-up event", 8'h18);
        step(1, 8'hE7, 3'b000, 3'b000, 4'b0000);
        step(0, 8'h00, 3'b000, 3'b000, 4'b0010);
        check("R12 sleep leaves bank and flags", 8'hF7);
        step(1, 8'h00, 3'b000, 3'b000, 4'b0001);
        check("R12 R4 write with timeout", 8'h00);
    endtask

    task automatic t_priority();
        do_reset();
        step(0, 8'h00, 3'b000, 3'b000, 4'b0011);
        check("R11 timeout over sleep", 8'h08);
        step(0, 8'h00, 3'b000, 3'b000, 4'b0110);
        check("R11 clear over sleep", 8'h18);
        step(0, 8'h00, 3'b000, 3'b000, 4'b0101);
        check("R11 timeout over clear", 8'h08);
        step(0, 8'h00, 3'b000, 3'b000, 4'b1001);
        check("R11 power-up over timeout", 8'h18);
    endtask

    initial begin
        idle();
        rst_n = 0;
        @(negedge clk);
        t_reset();
        t_plain_write();
        t_alu_update();
        t_clear_instr();
        t_events();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule